// File: doc/BRIEF.md
# Synchronous Request Tag Matcher

This block follows one synchronous request at a time and sorts every received message into one of two groups. The first group is the response to that request. Everything else is unsolicited traffic. When a request is accepted, the block stores a 16-bit tag built from the first two request bytes. The high byte of the tag is the second request byte. Each message header that arrives after that is compared against the stored tag. The comparison uses header byte 2 as the high half and header byte 0 as the low half.

A header that matches raises the completion strobe, clears the stored tag and ends the wait. A header that does not match raises the dispatch strobe. A cycle counter bounds the wait. If no response arrives within the set number of cycles, the block raises a timeout strobe and drops the tag, so a response that arrives late is treated as unsolicited. Only one request may be outstanding. A request that arrives while the block is busy is refused. Message storage stays outside the block. The block only produces routing decisions and status.

Top module: `sync_tag_matcher`

## Requirements
- R1: After a synchronous reset, `busy` is low and `req_ack`, `req_nack`, `sync_done`, `sync_timeout` and `disp_valid` are all low.
- R2: A request strobe taken while `busy` is low makes `req_ack` pulse and `busy` go high one cycle later. The stored tag is {`req_b1`, `req_b0`}, with `req_b1` as the high byte.
- R3: A request strobe taken while `busy` is high makes `req_nack` pulse one cycle later. The stored tag does not change, so a response carrying the refused request's bytes is dispatched.
- R4: A received header taken while `busy` is high, with {`rx_b2`, `rx_b0`} equal to the stored tag, makes `sync_done` pulse one cycle later. In that cycle `disp_valid` stays low and `busy` drops.
- R5: The match uses byte 2 as the high half. A header whose `rx_b0` and `rx_b2` values are swapped relative to the tag is dispatched.
- R6: A non-matching header taken while `busy` is high makes `disp_valid` pulse one cycle later. `busy` stays high.
- R7: While `busy` is low, every received header is dispatched, including an all-zero header. This still holds when a request is accepted in the same cycle as the header.
- R8: If no match is taken within TIMEOUT_CYCLES cycles of the request being accepted, `sync_timeout` pulses and `busy` drops. `busy` is high for exactly TIMEOUT_CYCLES cycles.
- R9: After a timeout the stored tag is cleared. A late matching header is dispatched.
- R10: A match taken in the last cycle of the wait wins over the timeout. `sync_done` pulses and `sync_timeout` does not.
- R11: Every output strobe is a single-cycle pulse, delivered one cycle after its cause. No strobe fires without a cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Synchronous request strobe |
| req_b0 | input | 8 | Request byte 0, low half of the tag |
| req_b1 | input | 8 | Request byte 1, high half of the tag |
| rx_valid | input | 1 | Received-header strobe |
| rx_b0 | input | 8 | Header byte 0, compared with the low half of the tag |
| rx_b2 | input | 8 | Header byte 2, compared with the high half of the tag |
| req_ack | output | 1 | Request accepted pulse |
| req_nack | output | 1 | Request refused pulse |
| sync_done | output | 1 | Header routed to synchronous completion |
| sync_timeout | output | 1 | Wait ended without a response |
| disp_valid | output | 1 | Header routed to general dispatch |
| busy | output | 1 | A synchronous request is outstanding |

## Verification
The hardest case to reach is a collision with the end of the wait: a matching header taken in exactly the last cycle before the timeout. A close second is a request and a matching header taken in the same cycle, both while busy and while idle. The bench runs with a short timeout. It counts clock cycles from the accepting edge, then places the response header on the final cycle, one cycle earlier than the timeout case. It also drives the request and receive strobes together in a single cycle, and the scoreboard expects the combined strobe pattern.

// File: rtl/tagm_pkg.sv
package tagm_pkg;
  parameter int BYTE_W = 8;
  localparam int TAG_W = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [TAG_W-1:0]  tag_t;

  typedef struct packed {
    logic ack;
    logic nack;
    logic done;
    logic tmo;
    logic disp;
  } strobe_t;

  function automatic tag_t make_tag(input byte_t hi, input byte_t lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/tagm_pending.sv
module tagm_pending
  import tagm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  tag_t new_tag,
  input  logic clear,
  output tag_t tag_q,
  output logic busy_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q  <= '0;
      busy_q <= 1'b0;
    end else if (take) begin
      tag_q  <= new_tag;
      busy_q <= 1'b1;
    end else if (clear) begin
      tag_q  <= '0;
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tagm_timer.sv
module tagm_timer #(
  parameter int TIMEOUT_CYCLES = 200_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic hit,
  output logic expire
);
  localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !busy || hit) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign expire = busy && !hit && (cnt_q == LAST);
endmodule

// File: rtl/tagm_route.sv
module tagm_route
  import tagm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    take,
  input  logic    refuse,
  input  logic    hit,
  input  logic    expire,
  input  logic    rx_valid,
  output strobe_t strb_q
);
  strobe_t strb_d;

  always_comb begin
    strb_d      = '0;
    strb_d.ack  = take;
    strb_d.nack = refuse;
    strb_d.done = hit;
    strb_d.tmo  = expire;
    strb_d.disp = rx_valid && !hit;
  end

  always_ff @(posedge clk) begin
    if (rst) strb_q <= '0;
    else     strb_q <= strb_d;
  end
endmodule

// File: rtl/sync_tag_matcher.sv
module sync_tag_matcher
  import tagm_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 200_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [BYTE_W-1:0] req_b0,
  input  logic [BYTE_W-1:0] req_b1,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_b0,
  input  logic [BYTE_W-1:0] rx_b2,
  output logic              req_ack,
  output logic              req_nack,
  output logic              sync_done,
  output logic              sync_timeout,
  output logic              disp_valid,
  output logic              busy
);
  tag_t    pend_tag;
  logic    pend_busy;
  logic    take, refuse, hit, expire;
  strobe_t strb;

  assign take   = req_valid && !pend_busy;
  assign refuse = req_valid && pend_busy;
  assign hit    = rx_valid && pend_busy && (make_tag(rx_b2, rx_b0) == pend_tag);

  tagm_pending u_pend (
    .clk(clk), .rst(rst), .take(take), .new_tag(make_tag(req_b1, req_b0)),
    .clear(hit || expire), .tag_q(pend_tag), .busy_q(pend_busy)
  );

  tagm_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .busy(pend_busy), .hit(hit), .expire(expire)
  );

  tagm_route u_route (
    .clk(clk), .rst(rst), .take(take), .refuse(refuse), .hit(hit),
    .expire(expire), .rx_valid(rx_valid), .strb_q(strb)
  );

  assign req_ack      = strb.ack;
  assign req_nack     = strb.nack;
  assign sync_done    = strb.done;
  assign sync_timeout = strb.tmo;
  assign disp_valid   = strb.disp;
  assign busy         = pend_busy;
endmodule

// File: rtl/tagm_checker.sv
module tagm_checker #(
  parameter int TIMEOUT_CYCLES = 200_000_000
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic req_ack,
  input logic req_nack,
  input logic sync_done,
  input logic sync_timeout,
  input logic disp_valid
);
  localparam int BW = $clog2(TIMEOUT_CYCLES + 1);
  logic [BW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_run <= '0;
    else              busy_run <= busy_run + 1'b1;
  end

  // R2
  ack_busy_chk: assert property (@(posedge clk) disable iff (rst) req_ack |-> busy);
  // R3
  nack_prior_chk: assert property (@(posedge clk) disable iff (rst) req_nack |-> $past(busy));
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) sync_done |-> !busy);
  // R4
  done_not_disp_chk: assert property (@(posedge clk) disable iff (rst) sync_done |-> !disp_valid);
  // R8
  tmo_idle_chk: assert property (@(posedge clk) disable iff (rst) sync_timeout |-> !busy);
  // R8
  busy_limit_chk: assert property (@(posedge clk) disable iff (rst) busy |-> (busy_run < BW'(TIMEOUT_CYCLES)));
  // R10
  done_tmo_excl_chk: assert property (@(posedge clk) disable iff (rst) !(sync_done && sync_timeout));
  // R11
  ack_nack_excl_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({req_ack, req_nack}));
endmodule

bind sync_tag_matcher tagm_checker #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .req_ack(req_ack), .req_nack(req_nack),
  .sync_done(sync_done), .sync_timeout(sync_timeout), .disp_valid(disp_valid)
);

// File: tb/sim_sync_tag_matcher.sv
`timescale 1ns/1ps
module sim_sync_tag_matcher;
  localparam int T = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, rx_valid = 1'b0;
  logic [7:0] req_b0 = '0, req_b1 = '0, rx_b0 = '0, rx_b2 = '0;
  logic req_ack, req_nack, sync_done, sync_timeout, disp_valid, busy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // expected strobe vectors {ack,nack,done,tmo,disp}
  logic [4:0] qv[$];
  string      qr[$];

  always #2.5 clk = ~clk;

  sync_tag_matcher #(.TIMEOUT_CYCLES(T)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_b0(req_b0), .req_b1(req_b1),
    .rx_valid(rx_valid), .rx_b0(rx_b0), .rx_b2(rx_b2), .req_ack(req_ack),
    .req_nack(req_nack), .sync_done(sync_done), .sync_timeout(sync_timeout),
    .disp_valid(disp_valid), .busy(busy)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // monitor: every strobe pattern must match the next expected item (R11)
  always @(negedge clk) begin
    logic [4:0] obs;
    obs = {req_ack, req_nack, sync_done, sync_timeout, disp_valid};
    if (!rst && obs != 5'b0) begin
      if (qv.size() == 0) chk(1'b0, "R11 unexpected strobe", obs, 0);
      else begin
        logic [4:0] e;
        string r;
        e = qv.pop_front();
        r = qr.pop_front();
        chk(obs == e, r, obs, e);
      end
    end
  end

  task automatic cyc(input bit rq, input logic [7:0] a0, input logic [7:0] a1,
                     input bit rv, input logic [7:0] h0, input logic [7:0] h2,
                     input logic [4:0] exp, input string r);
    @(negedge clk);
    if (exp != 5'b0) begin qv.push_back(exp); qr.push_back(r); end
    req_valid = rq; req_b0 = a0; req_b1 = a1;
    rx_valid = rv; rx_b0 = h0; rx_b2 = h2;
    @(negedge clk);
    req_valid = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [4:0] ACK = 5'b10000, NACK = 5'b01000, DONE = 5'b00100,
                         TMO = 5'b00010, DISP = 5'b00001;

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && {req_ack, req_nack, sync_done, sync_timeout, disp_valid} == 0,
        "R1 reset state", busy, 0);
    rst = 1'b0;
    // R7 idle zero header dispatched
    cyc(0, 0, 0, 1, 8'h00, 8'h00, DISP, "R7 idle zero header");
    // R2 accept
    cyc(1, 8'h21, 8'h15, 0, 0, 0, ACK, "R2 accept");
    chk(busy == 1, "R2 busy after accept", busy, 1);
    // R6 non-matching while busy
    cyc(0, 0, 0, 1, 8'h21, 8'h99, DISP, "R6 non-match dispatched");
    chk(busy == 1, "R6 busy kept", busy, 1);
    // R5 swapped bytes
    cyc(0, 0, 0, 1, 8'h15, 8'h21, DISP, "R5 swapped bytes dispatched");
    // R3 refused request, tag unchanged
    cyc(1, 8'h33, 8'h44, 0, 0, 0, NACK, "R3 refused");
    cyc(0, 0, 0, 1, 8'h33, 8'h44, DISP, "R3 refused tag not latched");
    // R4 match
    cyc(0, 0, 0, 1, 8'h21, 8'h15, DONE, "R4 match completes");
    chk(busy == 0, "R4 busy cleared", busy, 0);
    cyc(0, 0, 0, 1, 8'h21, 8'h15, DISP, "R7 repeat after completion dispatched");
    // R7 request and header in same idle cycle
    cyc(1, 8'h01, 8'h02, 1, 8'h01, 8'h02, ACK | DISP, "R7 same-cycle idle header");
    // R3/R4 refuse and match in one busy cycle
    cyc(1, 8'h55, 8'h66, 1, 8'h01, 8'h02, NACK | DONE, "R3 R4 refuse with match");
    idle(1);
    chk(sync_done == 0 && busy == 0, "R11 single pulse", sync_done, 0);
    // R8 timeout
    cyc(1, 8'h05, 8'h06, 0, 0, 0, ACK, "R8 accept");
    qv.push_back(TMO); qr.push_back("R8 timeout strobe");
    idle(T - 1);
    chk(busy == 1 && sync_timeout == 0, "R8 busy before limit", busy, 1);
    idle(1);
    chk(sync_timeout == 1 && busy == 0, "R8 timeout at limit", sync_timeout, 1);
    // R9 late response
    cyc(0, 0, 0, 1, 8'h05, 8'h06, DISP, "R9 late response dispatched");
    // R10 match on last cycle
    cyc(1, 8'h07, 8'h08, 0, 0, 0, ACK, "R10 accept");
    idle(T - 2);
    cyc(0, 0, 0, 1, 8'h07, 8'h08, DONE, "R10 last-cycle match wins");
    chk(sync_timeout == 0 && busy == 0, "R10 no timeout", sync_timeout, 0);
    idle(T + 2);
    chk(qv.size() == 0, "R11 all expected strobes seen", qv.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule